// File: doc/BRIEF.md
# Burst Waveform Table Playback Sequencer

This block plays back one channel of a waveform held in an external 16k-entry sample table. A 30-bit read phase with 16 fractional bits advances by a programmable step on every running cycle. Its integer part is the table address. When the phase reaches a programmable wrap point, it either keeps the overshoot or restarts from a programmable start phase.

A trigger starts a burst. The trigger can be immediate, an edge on an external line, or a software pulse. A burst runs a set number of full table passes. It then holds a final value for a programmed number of clocks, and then either waits a gap measured in microseconds and starts another burst, or returns to idle. Every table sample is scaled by a 14-bit unsigned gain, where 0x2000 means unity. An offset is added and the result is saturated to the signed 14-bit range before it leaves the block.

Configuration arrives through a write-only word port. The table is read through a synchronous read port with one cycle of latency.

Top module: `wave_burst_player`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` into the word selected by `wr_addr`. The words are: 0 control {trigger select [3:0], wrap mode [4], force zero [5], sequencer reset [6]}; 1 gain {scale [13:0], offset [29:16]}; 2 wrap point [29:0]; 3 start phase [29:0]; 4 step [29:0]; 5 passes per burst [15:0]; 6 repeat count [15:0]; 7 gap in microseconds [31:0]; 8 last value [13:0]; 9 initial value [13:0]; 10 hold length [31:0]. Scale resets to 0x2000 and every other field resets to zero.
- R2: After reset, and whenever the sequencer is idle or waiting in a gap, `dac_out` shows the initial value, two clocks after the state is entered.
- R3: A trigger is accepted only in idle and only while trigger select is 1, 2 or 3. Code 1 fires at once. Code 2 fires on a rising edge of `ext_trig`. Code 3 fires on a falling edge of `ext_trig`. A `sw_trig` pulse fires under any of these three codes. Under any other code, every trigger source is ignored. When a trigger is accepted, the phase loads the start phase, so `table_addr` equals start[29:16] in the next cycle.
- R4: On every running cycle without a wrap, the phase grows by the step, and `table_addr` is phase[29:16].
- R5: When phase + step is greater than or equal to the wrap point, a pass completes. With wrap mode 1 the next phase is (phase + step − wrap point). With wrap mode 0 it is the start phase.
- R6: For a sample that was addressed while running, `dac_out` equals saturate(floor(sample × scale / 8192) + offset) two clocks later. Sample and offset are signed; scale is unsigned.
- R7: With passes N ≠ 0, a burst ends on its Nth pass completion. With N = 0, the burst never ends.
- R8: After a burst ends, `dac_out` shows the last value for max(1, hold length) cycles.
- R9: After the hold, a repeat count of 0 returns the sequencer to idle. A count of N runs N more bursts, and 0xFFFF runs bursts forever. Each repeat first waits gap × CLK_MHZ + 1 cycles, then restarts from the start phase.
- R10: While force zero is set, `dac_out` is 0 from the clock after the control write.
- R11: While sequencer reset is set, the sequencer is idle, the phase holds the start phase, and triggers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 4 | Configuration word index |
| wr_data | input | 32 | Configuration write data |
| ext_trig | input | 1 | External trigger line, synchronous to clk |
| sw_trig | input | 1 | Software trigger pulse |
| table_addr | output | 14 | Sample table read address |
| table_data | input | 14 | Sample table read data, one clock after the address |
| dac_out | output | 14 | Scaled signed output sample |

## Verification
A wrong phase value shows on `table_addr` in the very next cycle. Its effect reaches `dac_out` two clocks later, because the table read and the output register both lie on that path. A wrong pass, hold, repeat or gap count does not show until the burst boundary. The output then moves to the last value, or back to the initial value, one or more cycles early or late. For that reason the bench compares every output cycle across whole multi-burst sequences, not only at single sample points.

// File: rtl/wave_burst_player.sv
module wave_burst_player #(
  parameter int SAMPLE_W = 14,
  parameter int ADDR_W   = 14,
  parameter int FRAC_W   = 16,
  parameter int CLK_MHZ  = 125
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [3:0]          wr_addr,
  input  logic [31:0]         wr_data,
  input  logic                ext_trig,
  input  logic                sw_trig,
  output logic [ADDR_W-1:0]   table_addr,
  input  logic [SAMPLE_W-1:0] table_data,
  output logic [SAMPLE_W-1:0] dac_out
);
  localparam int PH_W   = ADDR_W + FRAC_W;
  localparam int PRE_W  = $clog2(CLK_MHZ + 1);
  localparam int PROD_W = 2 * SAMPLE_W + 1;
  localparam logic [SAMPLE_W-1:0] UNITY = SAMPLE_W'(1) << (SAMPLE_W - 1);
  localparam logic [1:0] S_IDLE = 2'd0, S_RUN = 2'd1, S_HOLD = 2'd2, S_GAP = 2'd3;

  logic [3:0]          trig_sel;
  logic                wrap_mode, force_zero, seq_rst;
  logic [SAMPLE_W-1:0] scale, offset, last_val, init_val;
  logic [PH_W-1:0]     wrap_pt, start_pt, step;
  logic [15:0]         passes, repeats;
  logic [31:0]         gap_us, hold_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_sel <= '0; wrap_mode <= 1'b0; force_zero <= 1'b0; seq_rst <= 1'b0;
      scale <= UNITY; offset <= '0; last_val <= '0; init_val <= '0;
      wrap_pt <= '0; start_pt <= '0; step <= '0;
      passes <= '0; repeats <= '0; gap_us <= '0; hold_len <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        4'd0: begin
          trig_sel   <= wr_data[3:0];
          wrap_mode  <= wr_data[4];
          force_zero <= wr_data[5];
          seq_rst    <= wr_data[6];
        end
        4'd1: begin
          scale  <= wr_data[SAMPLE_W-1:0];
          offset <= wr_data[16 +: SAMPLE_W];
        end
        4'd2:  wrap_pt  <= wr_data[PH_W-1:0];
        4'd3:  start_pt <= wr_data[PH_W-1:0];
        4'd4:  step     <= wr_data[PH_W-1:0];
        4'd5:  passes   <= wr_data[15:0];
        4'd6:  repeats  <= wr_data[15:0];
        4'd7:  gap_us   <= wr_data;
        4'd8:  last_val <= wr_data[SAMPLE_W-1:0];
        4'd9:  init_val <= wr_data[SAMPLE_W-1:0];
        4'd10: hold_len <= wr_data;
        default: ;
      endcase
    end
  end

  logic ext_q;
  always_ff @(posedge clk) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_trig;
  end

  logic sel_ok, fire;
  assign sel_ok = (trig_sel != 4'd0) && (trig_sel < 4'd4);
  assign fire = !seq_rst && sel_ok &&
                (sw_trig || trig_sel == 4'd1 ||
                 (trig_sel == 4'd2 && ext_trig && !ext_q) ||
                 (trig_sel == 4'd3 && !ext_trig && ext_q));

  logic [1:0]       state;
  logic [PH_W-1:0]  acc;
  logic [15:0]      pass_cnt, rep_left;
  logic [31:0]      hold_cnt, gap_left;
  logic [PRE_W-1:0] pre;

  logic [PH_W:0]   sum;
  logic            wrap_hit, last_pass, more_reps;
  logic [PH_W-1:0] acc_wrapped;
  assign sum         = {1'b0, acc} + {1'b0, step};
  assign wrap_hit    = sum >= {1'b0, wrap_pt};
  assign acc_wrapped = wrap_mode ? PH_W'(sum - {1'b0, wrap_pt}) : start_pt;
  assign last_pass   = (passes != 16'd0) && (pass_cnt == passes - 16'd1);
  assign more_reps   = (repeats == 16'hFFFF) || (rep_left != 16'd0);
  assign table_addr  = acc[PH_W-1:FRAC_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; acc <= '0; pass_cnt <= '0; rep_left <= '0;
      hold_cnt <= '0; gap_left <= '0; pre <= '0;
    end else if (seq_rst) begin
      state <= S_IDLE; acc <= start_pt; pass_cnt <= '0; rep_left <= '0;
      hold_cnt <= '0; gap_left <= '0; pre <= '0;
    end else begin
      case (state)
        S_IDLE: if (fire) begin
          state    <= S_RUN;
          acc      <= start_pt;
          pass_cnt <= '0;
          rep_left <= repeats;
        end
        S_RUN: begin
          if (wrap_hit) begin
            if (last_pass) begin
              state    <= S_HOLD;
              hold_cnt <= hold_len;
            end else begin
              pass_cnt <= pass_cnt + 16'd1;
              acc      <= acc_wrapped;
            end
          end else begin
            acc <= sum[PH_W-1:0];
          end
        end
        S_HOLD: begin
          if (hold_cnt <= 32'd1) begin
            if (more_reps) begin
              state    <= S_GAP;
              gap_left <= gap_us;
              pre      <= '0;
              if (repeats != 16'hFFFF) rep_left <= rep_left - 16'd1;
            end else begin
              state <= S_IDLE;
            end
          end else begin
            hold_cnt <= hold_cnt - 32'd1;
          end
        end
        default: begin
          if (gap_left == 32'd0) begin
            state    <= S_RUN;
            acc      <= start_pt;
            pass_cnt <= '0;
          end else if (pre == PRE_W'(CLK_MHZ - 1)) begin
            pre      <= '0;
            gap_left <= gap_left - 32'd1;
          end else begin
            pre <= pre + PRE_W'(1);
          end
        end
      endcase
    end
  end

  logic                run_d;
  logic [SAMPLE_W-1:0] alt_d;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_d <= 1'b0;
      alt_d <= '0;
    end else begin
      run_d <= (state == S_RUN);
      alt_d <= (state == S_HOLD) ? last_val : init_val;
    end
  end

  logic signed [PROD_W-1:0] prod, mixed;
  logic                     ovf;
  logic [SAMPLE_W-1:0]      sat_val;
  assign prod  = PROD_W'($signed(table_data)) * PROD_W'($signed({1'b0, scale}));
  assign mixed = (prod >>> (SAMPLE_W - 1)) + PROD_W'($signed(offset));
  assign ovf   = !((&mixed[PROD_W-1:SAMPLE_W-1]) || !(|mixed[PROD_W-1:SAMPLE_W-1]));
  assign sat_val = ovf ? (mixed[PROD_W-1] ? {1'b1, {(SAMPLE_W-1){1'b0}}}
                                          : {1'b0, {(SAMPLE_W-1){1'b1}}})
                       : mixed[SAMPLE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)          dac_out <= '0;
    else if (force_zero) dac_out <= '0;
    else if (run_d)      dac_out <= sat_val;
    else                 dac_out <= alt_d;
  end
endmodule

// File: rtl/wave_burst_player_chk.sv
module wave_burst_player_chk #(
  parameter int PH_W     = 30,
  parameter int SAMPLE_W = 14
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          state,
  input logic                fire,
  input logic                seq_rst,
  input logic                force_zero,
  input logic [PH_W-1:0]     acc,
  input logic [PH_W-1:0]     start_pt,
  input logic [PH_W-1:0]     step,
  input logic [PH_W-1:0]     wrap_pt,
  input logic [SAMPLE_W-1:0] dac_out
);
  localparam logic [1:0] C_IDLE = 2'd0, C_RUN = 2'd1, C_HOLD = 2'd2, C_GAP = 2'd3;

  a_r3_trigger_loads_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_IDLE && fire) |=> (state == C_RUN && acc == $past(start_pt)));

  a_r4_phase_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_RUN && !seq_rst && ({1'b0, acc} + {1'b0, step} < {1'b0, wrap_pt}))
    |=> (acc == PH_W'($past(acc) + $past(step))));

  a_r8_hold_not_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_HOLD) |=> (state != C_RUN));

  a_r9_gap_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_GAP && !seq_rst) |=> (state == C_GAP || state == C_RUN));

  a_r10_force_zero: assert property (@(posedge clk) disable iff (!rst_n)
    force_zero |=> (dac_out == '0));

  a_r11_seq_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    seq_rst |=> (state == C_IDLE && acc == $past(start_pt)));
endmodule

bind wave_burst_player wave_burst_player_chk #(.PH_W(ADDR_W + FRAC_W), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .fire(fire), .seq_rst(seq_rst),
  .force_zero(force_zero), .acc(acc), .start_pt(start_pt), .step(step),
  .wrap_pt(wrap_pt), .dac_out(dac_out)
);

// File: tb/tb_wave_burst_player.sv
module tb_wave_burst_player;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ = 4;
  localparam logic [13:0] UNITY = 14'h2000;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, ext_trig = 1'b0, sw_trig = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [13:0] table_addr, table_data, dac_out;
  int n_checks = 0, n_fail = 0;

  wave_burst_player #(.CLK_MHZ(MHZ)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_trig(ext_trig), .sw_trig(sw_trig), .table_addr(table_addr),
    .table_data(table_data), .dac_out(dac_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [13:0] tdata(input logic [13:0] a);
    return (a * 14'd97) ^ {a[6:0], a[13:7]};
  endfunction

  function automatic int expv(input logic [13:0] d, input logic [13:0] sc, input logic [13:0] of);
    int p, q;
    p = int'($signed(d)) * int'({18'd0, sc});
    q = (p >>> 13) + int'($signed(of));
    if (q > 8191) q = 8191;
    if (q < -8192) q = -8192;
    return q;
  endfunction

  function automatic logic [31:0] cw(input int sel, input bit wm, input bit fz, input bit sr);
    return {25'd0, sr, fz, wm, 4'(sel)};
  endfunction

  always @(posedge clk) table_data <= tdata(table_addr);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wreg(input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [29:0] w, st, stp, e;
    logic [30:0] s31;
    logic [13:0] sc, of;
    bit wm, wrapped;
    int ha[0:39];
    int ex, cnt;
    string tag;

    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(dac_out == 14'd0, "R2 reset out", dac_out, 0);
    chk(table_addr == 14'd0, "R2 reset addr", table_addr, 0);

    wreg(9, 32'd11);
    repeat (2) @(negedge clk);
    chk(dac_out == 14'd11, "R1 R2 initial value", dac_out, 11);

    // multi-burst sequence with default unity gain
    wreg(8, 32'd77); wreg(10, 32'd5); wreg(6, 32'd1); wreg(7, 32'd2); wreg(5, 32'd2);
    wreg(2, 32'd4 << 16); wreg(4, 32'd1 << 16); wreg(3, 32'd0);
    wreg(0, cw(1, 0, 0, 0));
    wreg(0, cw(0, 0, 0, 0));
    for (int m = 0; m < 46; m++) begin
      if (m >= 2) begin
        if (m <= 9)       begin ex = expv(tdata(14'((m - 2) % 4)), UNITY, 14'd0); tag = "R1 R7 burst1"; end
        else if (m <= 14) begin ex = 77; tag = "R8 hold1"; end
        else if (m <= 23) begin ex = 11; tag = "R9 gap"; end
        else if (m <= 31) begin ex = expv(tdata(14'((m - 24) % 4)), UNITY, 14'd0); tag = "R7 burst2"; end
        else if (m <= 36) begin ex = 77; tag = "R8 hold2"; end
        else              begin ex = 11; tag = "R9 back to idle"; end
        chk(int'($signed(dac_out)) == ex, tag, int'($signed(dac_out)), ex);
      end
      @(negedge clk);
    end

    // phase accumulator and gain, directed extremes then random
    for (int r = 0; r < 6; r++) begin
      wreg(0, cw(0, 0, 0, 1));
      case (r)
        0: begin sc = 14'h3FFF; of = 14'h1FFF; end
        1: begin sc = 14'h3FFF; of = 14'h2000; end
        2: begin sc = 14'h0000; of = 14'h0123; end
        default: begin sc = 14'($urandom); of = 14'($urandom); end
      endcase
      wm  = r[0];
      w   = 30'((($urandom % 200) + 20) << 16) | 30'($urandom % 65536);
      stp = 30'($urandom % (4 << 16)) + 30'd1;
      st  = 30'($urandom % w);
      wreg(1, {2'b0, of, 2'b0, sc});
      wreg(2, {2'b0, w}); wreg(3, {2'b0, st}); wreg(4, {2'b0, stp}); wreg(5, 32'd0);
      wreg(0, cw(1, wm, 0, 0));
      wreg(0, cw(0, wm, 0, 0));
      e = st; wrapped = 1'b0;
      for (int n = 0; n < 40; n++) begin
        tag = (n == 0) ? "R3 start load" : (wrapped ? (wm ? "R5 wrap keep" : "R5 wrap restart") : "R4 step");
        chk(table_addr == e[29:16], tag, table_addr, e[29:16]);
        ha[n] = int'(e[29:16]);
        if (n >= 2) begin
          ex = expv(tdata(14'(ha[n-2])), sc, of);
          chk(int'($signed(dac_out)) == ex, "R6 scaled sample", int'($signed(dac_out)), ex);
        end
        s31 = {1'b0, e} + {1'b0, stp};
        wrapped = (s31 >= {1'b0, w});
        if (wrapped) e = wm ? 30'(s31 - {1'b0, w}) : st;
        else e = s31[29:0];
        @(negedge clk);
      end
    end

    // force zero while running (R7: passes 0 keeps running)
    wreg(0, cw(0, wm, 1, 0));
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(dac_out == 14'd0, "R10 force zero", dac_out, 0);
    end
    wreg(0, cw(0, wm, 0, 0));

    // sequencer reset holds idle and ignores immediate trigger
    wreg(0, cw(1, 0, 0, 1));
    repeat (3) @(negedge clk);
    chk(dac_out == 14'd11, "R11 reset shows initial", dac_out, 11);
    for (int k = 0; k < 5; k++) begin
      chk(table_addr == st[29:16], "R11 phase at start", table_addr, st[29:16]);
      @(negedge clk);
    end

    // trigger source selection
    wreg(3, 32'd5 << 16); wreg(4, 32'd1 << 16); wreg(2, 32'd1000 << 16);
    wreg(0, cw(0, 0, 0, 1));
    wreg(0, cw(0, 0, 0, 0));
    sw_trig = 1'b1; @(negedge clk); sw_trig = 1'b0;
    ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0;
    repeat (4) @(negedge clk);
    chk(table_addr == 14'd5, "R3 select 0 ignores all", table_addr, 5);
    chk(dac_out == 14'd11, "R3 select 0 stays idle", dac_out, 11);

    wreg(0, cw(2, 0, 0, 0));
    ext_trig = 1'b1;
    @(negedge clk); chk(table_addr == 14'd5, "R3 rising load", table_addr, 5);
    @(negedge clk); chk(table_addr == 14'd6, "R3 rising runs", table_addr, 6);

    wreg(0, cw(3, 0, 0, 1));
    ext_trig = 1'b0;
    wreg(0, cw(3, 0, 0, 0));
    ext_trig = 1'b1;
    repeat (3) @(negedge clk);
    chk(table_addr == 14'd5, "R3 falling select ignores rise", table_addr, 5);
    ext_trig = 1'b0;
    @(negedge clk); chk(table_addr == 14'd5, "R3 falling load", table_addr, 5);
    @(negedge clk); chk(table_addr == 14'd6, "R3 falling runs", table_addr, 6);

    wreg(0, cw(2, 0, 0, 1));
    wreg(0, cw(2, 0, 0, 0));
    sw_trig = 1'b1; @(negedge clk); sw_trig = 1'b0;
    @(negedge clk); chk(table_addr == 14'd6, "R3 software pulse", table_addr, 6);

    // endless repeats, then a single burst
    wreg(0, cw(0, 0, 0, 1));
    wreg(5, 32'd1); wreg(2, 32'd2 << 16); wreg(3, 32'd0); wreg(10, 32'd1);
    wreg(6, 32'hFFFF); wreg(7, 32'd0);
    wreg(0, cw(1, 0, 0, 0));
    wreg(0, cw(0, 0, 0, 0));
    repeat (200) @(negedge clk);
    cnt = 0;
    for (int k = 0; k < 8; k++) begin
      if (dac_out == 14'd77) cnt++;
      @(negedge clk);
    end
    chk(cnt == 2, "R9 endless repeats", cnt, 2);

    wreg(0, cw(0, 0, 0, 1));
    wreg(6, 32'd0);
    wreg(0, cw(1, 0, 0, 0));
    wreg(0, cw(0, 0, 0, 0));
    repeat (30) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      chk(dac_out == 14'd11, "R9 zero repeats idle", dac_out, 11);
      @(negedge clk);
    end

    summary();
    $finish;
  end
endmodule